// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Monitor

This block keeps the reservation for one hart's load-reserved / store-conditional pairs. A load-reserved request records the granule of the address it touches. A later store-conditional is allowed to write only if that reservation is still alive and covers the same granule. In the same cycle the block produces the value that goes to the destination register: 0 when the store goes ahead, 1 when it does not.

Several events kill the reservation. A write by another hart to the reserved granule, seen on the snoop port, kills it. So does a context switch on this hart, and so does an exception return. Every store-conditional also consumes the reservation, whether it succeeds or fails. A request whose address is not naturally aligned for its width raises a fault and leaves the reservation as it was.

Outputs are combinational from the request and the registered reservation. The reservation updates on the clock edge that ends the request cycle. The reservation granule is `2**GRAN_LG2` bytes and must be at least 8 bytes.

Top module: `lrsc_rsv_mon`

## Requirements
- R1: After an aligned LR (`req_op_i`=0), a later aligned SC (`req_op_i`=1) in the same granule succeeds, provided no event has killed the reservation in between. Success means `sc_go_o`=1 and `sc_status_o`=0.
- R2: A failing SC drives `sc_go_o`=0 and `sc_status_o`=1, with every upper bit at 0. When no SC is requested, `sc_go_o`=0 and `sc_status_o`=0.
- R3: Any aligned SC clears the reservation, whether it succeeds or fails. An SC that follows it without a new LR fails.
- R4: A snoop write (`snoop_valid_i`=1) to the reserved granule clears the reservation. A snoop write to any other granule leaves it intact.
- R5: A context switch (`ctx_switch_i`=1) clears the reservation.
- R6: An exception return (`exc_return_i`=1) clears the reservation.
- R7: A request is misaligned when `req_wide_i`=1 (64-bit) and `addr[2:0]`≠0, or when `req_wide_i`=0 (32-bit) and `addr[1:0]`≠0. A misaligned request sets `misalign_o`=1 and `sc_go_o`=0, and it does not change the reservation. A misaligned SC reports status 1.
- R8: An SC to a granule other than the reserved one fails, and it still clears the reservation.
- R9: A new aligned LR replaces any existing reservation. When an LR arrives in the same cycle as a snoop hit, a context switch or an exception return, the LR takes effect.
- R10: A snoop hit, a context switch or an exception return in the same cycle as an SC makes that SC fail.
- R11: After reset no reservation exists, so an SC fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | LR/SC request present |
| req_op_i | input | 1 | 0 = LR, 1 = SC |
| req_addr_i | input | ADDR_W | Request byte address |
| req_wide_i | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| snoop_valid_i | input | 1 | Write by another hart observed |
| snoop_addr_i | input | ADDR_W | Address of the observed write |
| ctx_switch_i | input | 1 | Context switch on this hart |
| exc_return_i | input | 1 | Exception return executed |
| sc_go_o | output | 1 | SC store may proceed |
| sc_status_o | output | XLEN | SC result for the destination register |
| misalign_o | output | 1 | Misaligned request fault |

## Verification
Random traffic draws addresses from a few granules, some of which share a granule and some of which are misaligned. This pool makes same-granule success, cross-granule failure and alignment faults all frequent. It also tells a compare on the whole word apart from a compare on the granule. Kill events and snoops land at random offsets from an LR, including the cycle of the LR itself and the cycle of the SC. This separates LR priority over kill events from a kill that falls on the SC itself. Directed sequences cover back-to-back SCs, LR replacement, snoops to a neighbouring granule, and an SC right after reset.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  typedef enum logic {
    OP_LR = 1'b0,
    OP_SC = 1'b1
  } rsv_op_e;
endpackage

// File: rtl/rsv_align_chk.sv
module rsv_align_chk #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wide_i,
  output logic              misaligned_o
);
  logic [2:0] low;
  assign low          = addr_i[2:0];
  assign misaligned_o = wide_i ? (low != 3'd0) : (low[1:0] != 2'd0);
endmodule

// File: rtl/rsv_store.sv
module rsv_store #(
  parameter int BLK_W = 26
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic [BLK_W-1:0] set_blk_i,
  input  logic             clr_i,
  output logic             valid_o,
  output logic [BLK_W-1:0] blk_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      blk_o   <= '0;
    end else if (set_i) begin
      valid_o <= 1'b1;
      blk_o   <= set_blk_i;
    end else if (clr_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/rsv_decide.sv
module rsv_decide #(
  parameter int BLK_W = 26,
  parameter int XLEN  = 64
) (
  input  logic             sc_req_i,
  input  logic             misaligned_i,
  input  logic             rsv_valid_i,
  input  logic [BLK_W-1:0] rsv_blk_i,
  input  logic [BLK_W-1:0] req_blk_i,
  input  logic             kill_now_i,
  output logic             go_o,
  output logic [XLEN-1:0]  status_o
);
  logic hit;
  assign hit  = rsv_valid_i && (rsv_blk_i == req_blk_i) && !kill_now_i;
  assign go_o = sc_req_i && !misaligned_i && hit;

  always_comb begin
    status_o    = '0;
    status_o[0] = sc_req_i && !go_o;
  end
endmodule

// File: rtl/lrsc_rsv_mon.sv
module lrsc_rsv_mon #(
  parameter int ADDR_W   = 32,
  parameter int XLEN     = 64,
  parameter int GRAN_LG2 = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_wide_i,
  input  logic              snoop_valid_i,
  input  logic [ADDR_W-1:0] snoop_addr_i,
  input  logic              ctx_switch_i,
  input  logic              exc_return_i,
  output logic              sc_go_o,
  output logic [XLEN-1:0]   sc_status_o,
  output logic              misalign_o
);
  import rsv_pkg::*;

  localparam int BLK_W = ADDR_W - GRAN_LG2;

  rsv_op_e    op;
  logic       misaligned, lr_ok, sc_req, sc_ok_addr, snoop_hit, kill_now;
  logic       rsv_valid;
  logic [BLK_W-1:0] rsv_blk, req_blk, snoop_blk;

  assign op        = rsv_op_e'(req_op_i);
  assign req_blk   = req_addr_i[ADDR_W-1:GRAN_LG2];
  assign snoop_blk = snoop_addr_i[ADDR_W-1:GRAN_LG2];

  rsv_align_chk #(.ADDR_W(ADDR_W)) u_align (
    .addr_i       (req_addr_i),
    .wide_i       (req_wide_i),
    .misaligned_o (misaligned)
  );

  assign misalign_o = req_valid_i && misaligned;
  assign lr_ok      = req_valid_i && (op == OP_LR) && !misaligned;
  assign sc_req     = req_valid_i && (op == OP_SC);
  assign sc_ok_addr = sc_req && !misaligned;
  assign snoop_hit  = snoop_valid_i && rsv_valid && (snoop_blk == rsv_blk);
  assign kill_now   = snoop_hit || ctx_switch_i || exc_return_i;

  // LR has priority over every clearing source
  rsv_store #(.BLK_W(BLK_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (lr_ok),
    .set_blk_i (req_blk),
    .clr_i     (sc_ok_addr || kill_now),
    .valid_o   (rsv_valid),
    .blk_o     (rsv_blk)
  );

  rsv_decide #(.BLK_W(BLK_W), .XLEN(XLEN)) u_decide (
    .sc_req_i     (sc_req),
    .misaligned_i (misaligned),
    .rsv_valid_i  (rsv_valid),
    .rsv_blk_i    (rsv_blk),
    .req_blk_i    (req_blk),
    .kill_now_i   (kill_now),
    .go_o         (sc_go_o),
    .status_o     (sc_status_o)
  );
endmodule

// File: rtl/lrsc_rsv_mon_chk.sv
module lrsc_rsv_mon_chk #(
  parameter int ADDR_W = 32,
  parameter int XLEN   = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_op_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              req_wide_i,
  input logic              ctx_switch_i,
  input logic              exc_return_i,
  input logic              sc_go_o,
  input logic [XLEN-1:0]   sc_status_o,
  input logic              misalign_o
);
  logic started;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) started <= 1'b0;
    else         started <= 1'b1;
  end

  logic sc_now, lr_now, bad_wide;
  assign sc_now   = req_valid_i && req_op_i;
  assign lr_now   = req_valid_i && !req_op_i && !misalign_o;
  assign bad_wide = req_valid_i && req_wide_i && ($countones(req_addr_i[2:0]) != 0);

  assert_go_source_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_go_o |-> sc_now && !misalign_o);
  assert_go_status_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_go_o |-> sc_status_o == '0);
  assert_fail_code_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_now && !sc_go_o) |-> sc_status_o == XLEN'(1));
  assert_idle_status_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sc_now |-> (sc_status_o == '0) && !sc_go_o);
  assert_sc_consumes_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started && sc_now && $past(sc_now && !misalign_o)) |-> !sc_go_o);
  assert_ctx_kill_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started && sc_now && $past(ctx_switch_i && !lr_now)) |-> !sc_go_o);
  assert_eret_kill_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started && sc_now && $past(exc_return_i && !lr_now)) |-> !sc_go_o);
  assert_misalign_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_wide |-> misalign_o && !sc_go_o);
  assert_same_cycle_kill_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_now && (ctx_switch_i || exc_return_i)) |-> !sc_go_o);
endmodule

bind lrsc_rsv_mon lrsc_rsv_mon_chk #(.ADDR_W(ADDR_W), .XLEN(XLEN)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_op_i     (req_op_i),
  .req_addr_i   (req_addr_i),
  .req_wide_i   (req_wide_i),
  .ctx_switch_i (ctx_switch_i),
  .exc_return_i (exc_return_i),
  .sc_go_o      (sc_go_o),
  .sc_status_o  (sc_status_o),
  .misalign_o   (misalign_o)
);

// File: tb/lrsc_rsv_mon_tb_top.sv
module lrsc_rsv_mon_tb_top;
  localparam int ADDR_W   = 32;
  localparam int XLEN     = 64;
  localparam int GRAN_LG2 = 6;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid_i = 0, req_op_i = 0, req_wide_i = 0;
  logic [ADDR_W-1:0] req_addr_i = '0, snoop_addr_i = '0;
  logic snoop_valid_i = 0, ctx_switch_i = 0, exc_return_i = 0;
  logic sc_go_o, misalign_o;
  logic [XLEN-1:0] sc_status_o;

  int checks = 0, failures = 0;
  bit done = 0;
  bit m_valid = 0;
  logic [ADDR_W-1:0] m_blk = '0;

  always #4 clk_i = ~clk_i;

  lrsc_rsv_mon #(.ADDR_W(ADDR_W), .XLEN(XLEN), .GRAN_LG2(GRAN_LG2)) dut_i (.*);

  function automatic logic [ADDR_W-1:0] blk_of(input logic [ADDR_W-1:0] a);
    return a >> GRAN_LG2;
  endfunction

  function automatic bit mis_of(input logic [ADDR_W-1:0] a, input bit w);
    return w ? (a % 8 != 0) : (a % 4 != 0);
  endfunction

  task automatic chk(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive one cycle, check against model, advance model
  task automatic step(input string tag, input bit v, input bit op, input logic [ADDR_W-1:0] a,
                      input bit w, input bit sv, input logic [ADDR_W-1:0] sa,
                      input bit cs, input bit er);
    bit mis, kill, exp_go, exp_mis;
    logic [XLEN-1:0] exp_st;
    @(negedge clk_i);
    req_valid_i = v; req_op_i = op; req_addr_i = a; req_wide_i = w;
    snoop_valid_i = sv; snoop_addr_i = sa; ctx_switch_i = cs; exc_return_i = er;
    #1;
    mis     = mis_of(a, w);
    kill    = cs || er || (sv && m_valid && blk_of(sa) == m_blk);
    exp_mis = v && mis;
    exp_go  = v && op && !mis && m_valid && blk_of(a) == m_blk && !kill;
    exp_st  = (v && op && !exp_go) ? XLEN'(1) : '0;
    chk({tag, " go"}, XLEN'(sc_go_o), XLEN'(exp_go));
    chk({tag, " status"}, sc_status_o, exp_st);
    chk({tag, " misalign"}, XLEN'(misalign_o), XLEN'(exp_mis));
    if (v && !op && !mis) begin m_valid = 1; m_blk = blk_of(a); end
    else if (v && op && !mis) m_valid = 0;
    else if (kill) m_valid = 0;
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 0, '0, 0, 0, '0, 0, 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R11: reset state
    idle("R11 idle");
    step("R11 sc after reset", 1, 1, 32'h100, 0, 0, '0, 0, 0);
    // R1: basic pair, same granule different word
    step("R1 lr", 1, 0, 32'h100, 1, 0, '0, 0, 0);
    step("R1 sc", 1, 1, 32'h138, 1, 0, '0, 0, 0);
    // R3: second sc fails
    step("R3 sc again", 1, 1, 32'h138, 1, 0, '0, 0, 0);
    // R8: other granule fails and clears
    step("R8 lr", 1, 0, 32'h200, 0, 0, '0, 0, 0);
    step("R8 sc other", 1, 1, 32'h240, 0, 0, '0, 0, 0);
    step("R8 sc after", 1, 1, 32'h200, 0, 0, '0, 0, 0);
    // R4: snoop elsewhere no effect, snoop hit kills
    step("R4 lr", 1, 0, 32'h300, 0, 0, '0, 0, 0);
    step("R4 snoop miss", 0, 0, '0, 0, 1, 32'h340, 0, 0);
    step("R4 sc ok", 1, 1, 32'h304, 0, 0, '0, 0, 0);
    step("R4 lr2", 1, 0, 32'h300, 0, 0, '0, 0, 0);
    step("R4 snoop hit", 0, 0, '0, 0, 1, 32'h33c, 0, 0);
    step("R4 sc fail", 1, 1, 32'h300, 0, 0, '0, 0, 0);
    // R5 / R6
    step("R5 lr", 1, 0, 32'h400, 1, 0, '0, 0, 0);
    step("R5 ctx", 0, 0, '0, 0, 0, '0, 1, 0);
    step("R5 sc", 1, 1, 32'h400, 1, 0, '0, 0, 0);
    step("R6 lr", 1, 0, 32'h400, 1, 0, '0, 0, 0);
    step("R6 eret", 0, 0, '0, 0, 0, '0, 0, 1);
    step("R6 sc", 1, 1, 32'h400, 1, 0, '0, 0, 0);
    // R7: misaligned sc has no effect on reservation
    step("R7 lr", 1, 0, 32'h500, 0, 0, '0, 0, 0);
    step("R7 sc 64 mis", 1, 1, 32'h504, 1, 0, '0, 0, 0);
    step("R7 lr mis", 1, 0, 32'h602, 0, 0, '0, 0, 0);
    step("R7 sc ok", 1, 1, 32'h500, 0, 0, '0, 0, 0);
    // R9: replace and priority
    step("R9 lr a", 1, 0, 32'h700, 0, 0, '0, 0, 0);
    step("R9 lr b with kill", 1, 0, 32'h800, 0, 1, 32'h700, 1, 1);
    step("R9 sc a", 1, 1, 32'h700, 0, 0, '0, 0, 0);
    step("R9 lr b", 1, 0, 32'h800, 0, 0, '0, 0, 0);
    step("R9 sc b", 1, 1, 32'h800, 0, 0, '0, 0, 0);
    // R10: kill in sc cycle
    step("R10 lr", 1, 0, 32'h900, 0, 0, '0, 0, 0);
    step("R10 sc+snoop", 1, 1, 32'h900, 0, 1, 32'h920, 0, 0);
    step("R10 lr2", 1, 0, 32'h900, 0, 0, '0, 0, 0);
    step("R10 sc+ctx", 1, 1, 32'h900, 0, 0, '0, 1, 0);
    // random mix, R1/R2
    for (int i = 0; i < 4000; i++) begin
      logic [ADDR_W-1:0] a, sa;
      a  = 32'h1000 + (($urandom % 4) << GRAN_LG2) + (($urandom % 4) * 8) + (($urandom % 8 == 0) ? 2 : 0);
      sa = 32'h1000 + (($urandom % 6) << GRAN_LG2);
      step("R1/R2 random", $urandom % 4 != 0, $urandom % 2, a, $urandom % 2,
           $urandom % 6 == 0, sa, $urandom % 16 == 0, $urandom % 16 == 0);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule